// File: doc/BRIEF.md
# Floating-Point NaN Propagation Selector

This unit picks the result of an IEEE-754 operation when at least one operand is a NaN. It also picks the result when a fused multiply-add multiplies zero by infinity. It serves two kinds of operation. Two-operand operations such as add or multiply use inputs A and B. Three-operand fused multiply-add computes a*b+c. An arithmetic datapath places this unit beside its own result path. When the unit reports that it has taken over, the arithmetic result is discarded and the selected NaN and invalid flag are used in its place. Rounding, tininess and flush-to-zero are handled elsewhere.

Two rule sets are available, chosen by the alternate-handling bit. The standard set prefers signalling NaNs over quiet ones and orders three-operand inputs C, A, B. It turns 0*Inf plus a quiet NaN into the default NaN, and its default NaN is positive. The alternate set takes the first NaN in plain operand order (A, B, C). It always passes the addend NaN through in the 0*Inf case, without raising invalid when that NaN is quiet, and its default NaN is negative. A separate default-NaN mode bit forces every NaN result to the default NaN of the active rule set.

The result can be combinational or held in one output register, chosen by a parameter. The default is the registered form.

Top module: `nan_pick_unit`

## Requirements
- R1: Format select `fmt` sets the exponent and fraction widths: 0 gives half precision (5/10 bits), 1 gives single (8/23), and 2 or 3 give double (11/52). Operand bits above the selected format's width are ignored. The result is right-aligned, with every bit above the format width zero.
- R2: `nanHit` is high exactly when a NaN is present among the operands in use, or when a fused multiply-add (`isFma`=1) has one multiplicand zero and the other infinite. Operand C is used only when `isFma`=1. While `nanHit` is low, `result` and `invalid` are zero.
- R3: Standard rules (`altMode`=0), two-operand: a signalling NaN wins over a quiet NaN. Between NaNs of the same class, A wins over B.
- R4: Standard rules, fused multiply-add: a signalling NaN wins over a quiet NaN first. Within the winning class the priority is C, then A, then B.
- R5: Standard rules, fused multiply-add with a 0*Inf product and a NaN in C: a quiet C gives the default NaN with `invalid` set. A signalling C is returned quieted.
- R6: Alternate rules (`altMode`=1), two-operand: the result comes from A if A is a NaN, otherwise from B, whatever the NaN class.
- R7: Alternate rules, fused multiply-add: the result comes from the first NaN in the order A, B, C.
- R8: Alternate rules, fused multiply-add with a 0*Inf product and a NaN in C: C is returned quieted. `invalid` is raised only if C is signalling.
- R9: Fused multiply-add with a 0*Inf or Inf*0 product and no NaN in C gives the default NaN with `invalid` set, under both rule sets.
- R10: The default NaN has its exponent all ones, only the top fraction bit set, and a sign equal to `altMode`. For half this is 0x7E00 (standard) or 0xFE00 (alternate). For single it is 0x7FC00000 or 0xFFC00000. For double it is 0x7FF8000000000000 or 0xFFF8000000000000.
- R11: A selected operand NaN is returned with its top fraction bit set and its sign and remaining payload unchanged.
- R12: `invalid` is raised whenever an operand in use is a signalling NaN, in addition to the cases in R5, R8 and R9.
- R13: With `dnMode`=1, every result with `nanHit` high is replaced by the default NaN of the active rule set. `invalid` is unchanged by this mode.
- R14: With `OUT_REG`=1, the outputs appear one clock after the inputs. An active-low `rstN` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 64 | Operand A (multiplicand a for fused multiply-add) |
| opB | input | 64 | Operand B (multiplicand b) |
| opC | input | 64 | Operand C (addend c), used only when isFma=1 |
| fmt | input | 2 | Format select: 0 half, 1 single, 2 or 3 double |
| isFma | input | 1 | 1 selects three-operand fused multiply-add |
| dnMode | input | 1 | Default-NaN mode enable |
| altMode | input | 1 | Alternate-handling rule set enable |
| nanHit | output | 1 | The unit supplies the result |
| result | output | 64 | Selected NaN, right-aligned |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions take the operand words to be settled, two-state encodings at every clock edge. They also take `fmt` and the mode bits to be stable together with the operands, because the assertions judge the combinational stage against the inputs present at that edge. The stimulus meets this by changing all inputs together on the falling edge, one vector per cycle. The sweep covers zero, infinity, a normal value, a quiet NaN, and positive and negative signalling NaNs in every operand. It runs over all three formats, both rule sets, both default-NaN settings and both arities. Every narrow-format operand carries junk in its upper bits, so the ignored-bits part of R1 is exercised throughout.

// File: rtl/nan_pick_pkg.sv
`timescale 1ns/1ps
package nan_pick_pkg;

  localparam int BUS_W    = 64;
  localparam int HALF_EW  = 5;
  localparam int HALF_FW  = 10;
  localparam int SNGL_EW  = 8;
  localparam int SNGL_FW  = 23;
  localparam int DBL_EW   = 11;
  localparam int DBL_FW   = 52;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_WIDE   = 2'd3
  } fpFmt_e;

  // Classification of one operand, produced by the datapath
  typedef struct packed {
    logic isNan;
    logic isSig;
    logic isInf;
    logic isZero;
  } opClass_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pickA;
    logic pickB;
    logic pickC;
    logic pickDflt;
    logic raiseInv;
    logic hit;
  } nanCtl_t;

  function automatic int fracWidth(fpFmt_e f);
    case (f)
      FMT_HALF:   return HALF_FW;
      FMT_SINGLE: return SNGL_FW;
      default:    return DBL_FW;
    endcase
  endfunction

  function automatic int expWidth(fpFmt_e f);
    case (f)
      FMT_HALF:   return HALF_EW;
      FMT_SINGLE: return SNGL_EW;
      default:    return DBL_EW;
    endcase
  endfunction

endpackage

// File: rtl/nan_pick_dp.sv
`timescale 1ns/1ps
module nan_pick_dp
  import nan_pick_pkg::*;
#(
  parameter int N_OPS = 3,
  parameter int W     = BUS_W
) (
  input  fpFmt_e                    fmt,
  input  logic [N_OPS-1:0][W-1:0]   ops,
  input  logic                      altMode,
  input  nanCtl_t                   ctl,
  output opClass_t [N_OPS-1:0]      opCls,
  output logic [W-1:0]              result
);

  logic [W-1:0] fracMask, expMask, signBit, quietBit, fmtMask;

  // Field masks for the selected format
  always_comb begin
    int fw;
    int ew;
    fw       = fracWidth(fmt);
    ew       = expWidth(fmt);
    fracMask = (W'(1) << fw) - W'(1);
    expMask  = ((W'(1) << ew) - W'(1)) << fw;
    signBit  = W'(1) << (ew + fw);
    quietBit = W'(1) << (fw - 1);
    fmtMask  = (signBit << 1) - W'(1);
  end

  // Per-operand classification
  for (genvar i = 0; i < N_OPS; i++) begin : g_class
    logic expOnes, fracZero;
    always_comb begin
      expOnes  = (ops[i] & expMask) == expMask;
      fracZero = (ops[i] & fracMask) == '0;
      opCls[i].isNan  = expOnes && !fracZero;
      opCls[i].isSig  = expOnes && !fracZero && ((ops[i] & quietBit) == '0);
      opCls[i].isInf  = expOnes && fracZero;
      opCls[i].isZero = ((ops[i] & (expMask | fracMask)) == '0);
    end
  end

  // Result mux driven by control strobes
  logic [N_OPS-1:0] pickVec;
  logic [W-1:0]     picked, dfltNan;

  assign pickVec = N_OPS'({ctl.pickC, ctl.pickB, ctl.pickA});
  assign dfltNan = expMask | quietBit | (altMode ? signBit : '0);

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_OPS; i++) begin
      if (pickVec[i]) picked = ops[i];
    end
  end

  always_comb begin
    if (!ctl.hit)         result = '0;
    else if (ctl.pickDflt) result = dfltNan;
    else                  result = (picked & fmtMask) | quietBit;
  end

endmodule

// File: rtl/nan_pick_ctl.sv
`timescale 1ns/1ps
module nan_pick_ctl
  import nan_pick_pkg::*;
(
  input  opClass_t [2:0] opCls,
  input  logic           isFma,
  input  logic           dnMode,
  input  logic           altMode,
  output nanCtl_t        ctl
);

  logic nanA, nanB, nanC, sigA, sigB, sigC;
  logic infZero, anyNan, anySig;

  always_comb begin
    nanA    = opCls[0].isNan;
    nanB    = opCls[1].isNan;
    nanC    = isFma && opCls[2].isNan;
    sigA    = opCls[0].isSig;
    sigB    = opCls[1].isSig;
    sigC    = isFma && opCls[2].isSig;
    infZero = isFma && ((opCls[0].isZero && opCls[1].isInf) ||
                        (opCls[0].isInf  && opCls[1].isZero));
    anyNan  = nanA || nanB || nanC;
    anySig  = sigA || sigB || sigC;
  end

  always_comb begin
    ctl          = '0;
    ctl.raiseInv = anySig;
    ctl.hit      = infZero || anyNan;
    if (infZero) begin
      if (nanC) begin
        if (altMode || sigC) ctl.pickC = 1'b1;
        else begin
          ctl.pickDflt = 1'b1;
          ctl.raiseInv = 1'b1;
        end
      end else begin
        ctl.pickDflt = 1'b1;
        ctl.raiseInv = 1'b1;
      end
    end else if (anyNan) begin
      if (altMode) begin
        if (nanA)      ctl.pickA = 1'b1;
        else if (nanB) ctl.pickB = 1'b1;
        else           ctl.pickC = 1'b1;
      end else if (isFma) begin
        if (anySig) begin
          if (sigC)      ctl.pickC = 1'b1;
          else if (sigA) ctl.pickA = 1'b1;
          else           ctl.pickB = 1'b1;
        end else begin
          if (nanC)      ctl.pickC = 1'b1;
          else if (nanA) ctl.pickA = 1'b1;
          else           ctl.pickB = 1'b1;
        end
      end else begin
        if (anySig) begin
          if (sigA) ctl.pickA = 1'b1;
          else      ctl.pickB = 1'b1;
        end else begin
          if (nanA) ctl.pickA = 1'b1;
          else      ctl.pickB = 1'b1;
        end
      end
    end
    if (dnMode && ctl.hit) begin
      ctl.pickA    = 1'b0;
      ctl.pickB    = 1'b0;
      ctl.pickC    = 1'b0;
      ctl.pickDflt = 1'b1;
    end
  end

  // R2
  always_comb begin
    pick_onehot_chk: assert ($countones({ctl.pickA, ctl.pickB, ctl.pickC, ctl.pickDflt})
                             == (ctl.hit ? 1 : 0));
  end

endmodule

// File: rtl/nan_pick_unit.sv
`timescale 1ns/1ps
module nan_pick_unit
  import nan_pick_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] opC,
  input  logic [1:0]  fmt,
  input  logic        isFma,
  input  logic        dnMode,
  input  logic        altMode,
  output logic        nanHit,
  output logic [63:0] result,
  output logic        invalid
);

  fpFmt_e              fmtSel;
  opClass_t [2:0]      opCls;
  nanCtl_t             ctl;
  logic [BUS_W-1:0]    stgResult;

  assign fmtSel = fpFmt_e'(fmt);

  nan_pick_dp #(.N_OPS(3), .W(BUS_W)) u_dp (
    .fmt     (fmtSel),
    .ops     ({opC, opB, opA}),
    .altMode (altMode),
    .ctl     (ctl),
    .opCls   (opCls),
    .result  (stgResult)
  );

  nan_pick_ctl u_ctl (
    .opCls   (opCls),
    .isFma   (isFma),
    .dnMode  (dnMode),
    .altMode (altMode),
    .ctl     (ctl)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nanHit  <= 1'b0;
        result  <= '0;
        invalid <= 1'b0;
      end else begin
        nanHit  <= ctl.hit;
        result  <= stgResult;
        invalid <= ctl.raiseInv;
      end
    end
  end else begin : g_comb
    assign nanHit  = ctl.hit;
    assign result  = stgResult;
    assign invalid = ctl.raiseInv;
  end

  // Independent field view for the checks below
  logic [BUS_W-1:0] chkExp, chkQuiet, chkSign, chkFrac, chkFmt;
  always_comb begin
    chkFrac  = (BUS_W'(1) << fracWidth(fmtSel)) - BUS_W'(1);
    chkQuiet = BUS_W'(1) << (fracWidth(fmtSel) - 1);
    chkSign  = BUS_W'(1) << (fracWidth(fmtSel) + expWidth(fmtSel));
    chkExp   = (chkSign - BUS_W'(1)) & ~chkFrac;
    chkFmt   = (chkSign << 1) - BUS_W'(1);
  end

  // R2
  nohit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.hit |-> (stgResult == '0 && !ctl.raiseInv));

  // R11
  quiet_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hit |-> ((stgResult & chkExp) == chkExp && (stgResult & chkQuiet) != '0
                 && (stgResult & ~chkFmt) == '0));

  // R12
  sig_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCls[0].isSig || opCls[1].isSig || (isFma && opCls[2].isSig)) |-> ctl.raiseInv);

  // R13
  dn_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnMode && ctl.hit) |-> ((stgResult & chkFrac) == chkQuiet
                             && ((stgResult & chkSign) != '0) == altMode));

  // R6
  alt_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (altMode && !dnMode && !isFma && opCls[0].isNan)
      |-> stgResult == ((opA & chkFmt) | chkQuiet));

endmodule

// File: tb/test_nan_pick_unit.sv
`timescale 1ns/1ps
module test_nan_pick_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] opA, opB, opC;
  logic [1:0]  fmt;
  logic        isFma, dnMode, altMode;
  logic        nanHit, invalid;
  logic [63:0] result;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  nan_pick_unit i_nan_pick_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opC(opC),
    .fmt(fmt), .isFma(isFma), .dnMode(dnMode), .altMode(altMode),
    .nanHit(nanHit), .result(result), .invalid(invalid)
  );

  localparam logic [63:0] JUNK = 64'hC3A5_96E1_7B2D_4F88;

  function automatic int fw(int f);
    return (f == 0) ? 10 : (f == 1) ? 23 : 52;
  endfunction
  function automatic int ew(int f);
    return (f == 0) ? 5 : (f == 1) ? 8 : 11;
  endfunction

  // cls: 0 zero, 1 inf, 2 normal, 3 qNaN, 4 sNaN, 5 negative sNaN
  function automatic logic [63:0] mkOp(int f, int cls, int idx);
    logic [63:0] ones, qb, s, e, fr;
    ones = (64'd1 << ew(f)) - 64'd1;
    qb   = 64'd1 << (fw(f) - 1);
    s = 0; e = 0; fr = 0;
    case (cls)
      0: begin s = 64'(idx & 1); end
      1: begin e = ones; end
      2: begin e = ones >> 1; fr = 64'(idx + 1); end
      3: begin e = ones; fr = qb | 64'(idx + 3); end
      4: begin e = ones; fr = 64'(idx + 3); end
      default: begin s = 1; e = ones; fr = 64'(idx + 5); end
    endcase
    return (s << (ew(f) + fw(f))) | (e << fw(f)) | fr;
  endfunction

  function automatic logic [63:0] dfltOf(int f, bit alt);
    return (64'(alt) << (ew(f) + fw(f))) | (((64'd1 << ew(f)) - 64'd1) << fw(f))
           | (64'd1 << (fw(f) - 1));
  endfunction

  task automatic applyOne(int f, bit alt, bit dn, bit fma, int ca, int cb, int cc);
    logic [63:0] cln [3];
    logic [63:0] fmtMask, expRes;
    bit nA, nB, nC, sA, sB, sC, infz, hit, inv, useDflt;
    int pick;
    string tag;
    cln[0] = mkOp(f, ca, 0);
    cln[1] = mkOp(f, cb, 1);
    cln[2] = mkOp(f, cc, 2);
    fmtMask = (f == 2) ? '1 : ((64'd1 << (1 + ew(f) + fw(f))) - 64'd1);
    @(negedge clk);
    // R1: junk above the format width must be ignored
    opA = cln[0] | (JUNK & ~fmtMask);
    opB = cln[1] | (JUNK & ~fmtMask);
    opC = cln[2] | (JUNK & ~fmtMask);
    fmt = 2'(f); isFma = fma; dnMode = dn; altMode = alt;

    nA = ca >= 3; nB = cb >= 3; nC = fma && cc >= 3;
    sA = ca >= 4; sB = cb >= 4; sC = fma && cc >= 4;
    infz = fma && ((ca == 0 && cb == 1) || (ca == 1 && cb == 0));
    hit = nA || nB || nC || infz;
    inv = sA || sB || sC;
    useDflt = 0; pick = 0; tag = "R2";
    if (infz) begin
      if (nC) begin
        tag = alt ? "R8" : "R5";
        if (alt || sC) pick = 2;
        else begin useDflt = 1; inv = 1; end
      end else begin
        tag = "R9"; useDflt = 1; inv = 1;
      end
    end else if (hit) begin
      if (alt) begin
        tag = fma ? "R7" : "R6";
        pick = nA ? 0 : nB ? 1 : 2;
      end else if (fma) begin
        tag = "R4";
        if (sA || sB || sC) pick = sC ? 2 : sA ? 0 : 1;
        else pick = nC ? 2 : nA ? 0 : 1;
      end else begin
        tag = "R3";
        if (sA || sB) pick = sA ? 0 : 1;
        else pick = nA ? 0 : 1;
      end
    end
    if (dn && hit) begin useDflt = 1; tag = "R13"; end
    if (!hit) expRes = '0;
    else if (useDflt) expRes = dfltOf(f, alt);            // R10
    else expRes = cln[pick] | (64'd1 << (fw(f) - 1));       // R11

    @(posedge clk);   // R14: one register stage
    #2;
    vectors++;
    if (nanHit !== hit || result !== expRes || invalid !== inv) begin
      misses++;
      if (invalid !== inv && nanHit === hit && result === expRes) tag = "R12";
      $display("FAIL %s fmt=%0d alt=%0d dn=%0d fma=%0d cls=%0d/%0d/%0d got hit=%0b res=%h inv=%0b exp hit=%0b res=%h inv=%0b",
               tag, f, alt, dn, fma, ca, cb, cc, nanHit, result, invalid, hit, expRes, inv);
    end
  endtask

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    opA = 64'h7FF4_0000_0000_0001; opB = 0; opC = 0;
    fmt = 2'd2; isFma = 0; dnMode = 0; altMode = 0;
    repeat (3) @(negedge clk);
    // R14: outputs held at zero during reset despite a signalling NaN input
    vectors++;
    if (nanHit !== 1'b0 || result !== 64'd0 || invalid !== 1'b0) begin
      misses++;
      $display("FAIL R14 reset got hit=%0b res=%h inv=%0b exp hit=0 res=0 inv=0",
               nanHit, result, invalid);
    end
    rstN = 1'b1;
    for (int f = 0; f < 3; f++)
      for (int m = 0; m < 8; m++)
        for (int ca = 0; ca < 6; ca++)
          for (int cb = 0; cb < 6; cb++)
            for (int cc = 0; cc < 6; cc++)
              applyOne(f, m[0], m[1], m[2], ca, cb, cc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule